// File: doc/BRIEF.md
# Serial Avionics Word Transmitter with Eight-Word Queue

This block takes 32-bit data words from a 16-bit parallel bus, one half per strobe, and holds them in an eight-entry queue. While the send-enable input is high, it takes words from the head of the queue and shifts them out one at a time on a pair of return-to-zero outputs. One output pulses for a one bit and the other pulses for a zero bit. Both outputs are low for the rest of each bit cell and during the gap between words.

The block runs from a single clock at DIV (default ten) times the bit rate. It places a generated parity bit in the last bit position of every word, with odd or even sense chosen by an input. A second input selects a 32-bit or a 25-bit word. A timer holds at least four null bit cells between consecutive words. The block also drives a bit-rate clock output and a queue-empty flag. The parity-sense and word-length settings are plain inputs, and reset does not touch them.

Top module: `a429_tx_fifo`

## Requirements
- R1: A pulse on `load_lo` stores `din` as word bits 15:0. A later pulse on `load_hi` forms the word `{din, stored half}` and appends it to the queue. Data bits are sent least significant bit first.
- R2: The queue holds at most 8 words. A `load_hi` pulse that arrives while 8 words are queued is dropped, even when a word leaves the queue in that same cycle.
- R3: A word leaves the queue only at the end of a bit cell, only while `tx_en` is high, and only when the line is idle or in its last gap cell. Once a word has started, it is sent in full even if `tx_en` falls.
- R4: Each bit cell lasts DIV clocks. During the first DIV/2 clocks, `line_hi` is 1 for a one bit and `line_lo` is 1 for a zero bit. During the rest of the cell, both outputs are 0. The two outputs are never 1 together.
- R5: The last bit of each word is parity computed over the data bits sent. With `par_even`=0 the total count of ones in the word is odd; with `par_even`=1 it is even.
- R6: With `short_word`=0 a word is 32 bits long (31 data bits and parity). With `short_word`=1 it is 25 bits long (data bits 23:0 and parity). Both settings are sampled when the word leaves the queue.
- R7: Between the last bit cell of one word and the first bit cell of the next, at least four full bit cells pass with both outputs at 0.
- R8: `bit_clk` runs continuously with a period of DIV clocks. It is high during the first half of every bit cell.
- R9: `fifo_empty` is 1 exactly when no word is queued.
- R10: While `rst_n` is low, the queue is emptied, both line outputs are 0, and the bit-cell phase restarts with `bit_clk` high. Queued words are not sent after reset is released.

Transmission is described by a GAP_CELLS generic: the gap from R7 is that many null bit cells, with a default of 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at DIV times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 16 | Parallel half-word input |
| load_lo | input | 1 | Strobe that stores the low half |
| load_hi | input | 1 | Strobe that stores the high half and queues the word |
| tx_en | input | 1 | Allows words to leave the queue |
| par_even | input | 1 | Parity sense: 0 selects odd, 1 selects even |
| short_word | input | 1 | Word length: 0 selects 32 bits, 1 selects 25 bits |
| line_hi | output | 1 | Return-to-zero pulse for a one bit |
| line_lo | output | 1 | Return-to-zero pulse for a zero bit |
| bit_clk | output | 1 | Bit-rate clock |
| fifo_empty | output | 1 | Queue-empty flag |

## Verification
A `load_hi` push and a queue pop can fall in the same clock. The bench forces this by raising `tx_en` together with `load_hi` in the clock just before a cell boundary. It does this once with a single queued word, where both words must go out in order, and once with a full queue, where the new word must be dropped. A behavioural model built on a queue predicts every output on every clock. A decoder in the bench rebuilds each word from the line pulses and checks its length, data, parity and gap.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_SEND = 2'd1,
      TX_GAP  = 2'd2
   } tx_state_t;

   localparam int unsigned HALF_W_DEF = 16;
endpackage

// File: rtl/a429_bit_timer.sv
module a429_bit_timer #(
   parameter int unsigned DIV = 10
) (
   input  logic clk,
   input  logic rst_n,
   output logic cell_end,
   output logic first_half
);
   localparam int unsigned CW   = (DIV > 2) ? $clog2(DIV) : 1;
   localparam int unsigned HALF = DIV / 2;

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("a429_bit_timer: DIV must be even and at least 2");
      end
   endgenerate

   logic [CW-1:0] phase_q;

   assign cell_end   = (phase_q == CW'(DIV - 1));
   assign first_half = (phase_q < CW'(HALF));

   always_ff @(posedge clk) begin
      if (!rst_n)        phase_q <= '0;
      else if (cell_end) phase_q <= '0;
      else               phase_q <= phase_q + 1'b1;
   end
endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [WIDTH-1:0]               push_data,
   input  logic                           pop,
   output logic [WIDTH-1:0]               pop_data,
   output logic                           empty,
   output logic [$clog2(DEPTH+1)-1:0]     count
);
   localparam int unsigned PW    = (DEPTH > 2) ? $clog2(DEPTH) : 1;
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("a429_word_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic             full, do_push, do_pop;

   assign full     = (count == CNT_W'(DEPTH));
   assign empty    = (count == '0);
   assign do_push  = push && !full;
   assign do_pop   = pop && !empty;
   assign pop_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) begin
            mem[wr_ptr] <= push_data;
            wr_ptr      <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         end
         if (do_pop)
            rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/a429_serializer.sv
module a429_serializer
   import a429_tx_pkg::*;
#(
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned LONG_LEN  = 32,
   parameter int unsigned SHORT_LEN = 25,
   parameter int unsigned GAP_CELLS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cell_end,
   input  logic              first_half,
   input  logic              tx_en,
   input  logic              fifo_empty,
   input  logic              par_even,
   input  logic              short_word,
   input  logic [WORD_W-1:0] word_in,
   output logic              pop,
   output logic              line_hi,
   output logic              line_lo
);
   localparam int unsigned IDX_W = $clog2(WORD_W);
   localparam int unsigned GAP_W = $clog2(GAP_CELLS + 1);

   generate
      if (LONG_LEN > WORD_W || SHORT_LEN > LONG_LEN || SHORT_LEN < 2) begin : g_bad_len
         $error("a429_serializer: word lengths out of range");
      end
      if (GAP_CELLS < 1) begin : g_bad_gap
         $error("a429_serializer: GAP_CELLS must be at least 1");
      end
   endgenerate

   tx_state_t         state_q;
   logic [WORD_W-1:0] shreg_q, frame;
   logic [IDX_W-1:0]  idx_q, last_q;
   logic [GAP_W-1:0]  gap_q;
   logic [IDX_W:0]    len_sel;
   logic              data_par, par_bit, start;

   generate
      if (SHORT_LEN == LONG_LEN) begin : g_fixed_len
         assign len_sel = (IDX_W+1)'(LONG_LEN);
      end else begin : g_sel_len
         assign len_sel = short_word ? (IDX_W+1)'(SHORT_LEN) : (IDX_W+1)'(LONG_LEN);
      end
   endgenerate

   always_comb begin
      frame    = '0;
      data_par = 1'b0;
      for (int i = 0; i < int'(WORD_W); i++) begin
         if (i < int'(len_sel) - 1) begin
            frame[i] = word_in[i];
            data_par = data_par ^ word_in[i];
         end
      end
      par_bit = data_par ^ ~par_even;
      for (int i = 0; i < int'(WORD_W); i++) begin
         if (i == int'(len_sel) - 1) frame[i] = par_bit;
      end
   end

   assign start = cell_end && tx_en && !fifo_empty &&
                  (state_q == TX_IDLE ||
                   (state_q == TX_GAP && gap_q == GAP_W'(GAP_CELLS - 1)));
   assign pop   = start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= TX_IDLE;
         shreg_q <= '0;
         idx_q   <= '0;
         last_q  <= '0;
         gap_q   <= '0;
      end else if (start) begin
         state_q <= TX_SEND;
         shreg_q <= frame;
         idx_q   <= '0;
         last_q  <= IDX_W'(len_sel - 1'b1);
      end else if (cell_end) begin
         case (state_q)
            TX_SEND: begin
               if (idx_q == last_q) begin
                  state_q <= TX_GAP;
                  gap_q   <= '0;
               end else begin
                  shreg_q <= shreg_q >> 1;
                  idx_q   <= idx_q + 1'b1;
               end
            end
            TX_GAP: begin
               if (gap_q == GAP_W'(GAP_CELLS - 1)) state_q <= TX_IDLE;
               else                                gap_q   <= gap_q + 1'b1;
            end
            default: state_q <= TX_IDLE;
         endcase
      end
   end

   assign line_hi = (state_q == TX_SEND) && first_half &&  shreg_q[0];
   assign line_lo = (state_q == TX_SEND) && first_half && !shreg_q[0];
endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo
   import a429_tx_pkg::*;
#(
   parameter int unsigned HALF_W    = HALF_W_DEF,
   parameter int unsigned DEPTH     = 8,
   parameter int unsigned DIV       = 10,
   parameter int unsigned LONG_LEN  = 32,
   parameter int unsigned SHORT_LEN = 25,
   parameter int unsigned GAP_CELLS = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HALF_W-1:0] din,
   input  logic              load_lo,
   input  logic              load_hi,
   input  logic              tx_en,
   input  logic              par_even,
   input  logic              short_word,
   output logic              line_hi,
   output logic              line_lo,
   output logic              bit_clk,
   output logic              fifo_empty
);
   localparam int unsigned WORD_W = 2 * HALF_W;
   localparam int unsigned CNT_W  = $clog2(DEPTH + 1);

   logic [HALF_W-1:0] half_q;
   logic [WORD_W-1:0] head_word;
   logic [CNT_W-1:0]  fifo_count;
   logic              pop_w, cell_end, first_half;

   always_ff @(posedge clk) begin
      if (!rst_n)       half_q <= '0;
      else if (load_lo) half_q <= din;
   end

   a429_bit_timer #(.DIV(DIV)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .cell_end   (cell_end),
      .first_half (first_half)
   );

   a429_word_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (load_hi),
      .push_data ({din, half_q}),
      .pop       (pop_w),
      .pop_data  (head_word),
      .empty     (fifo_empty),
      .count     (fifo_count)
   );

   a429_serializer #(
      .WORD_W    (WORD_W),
      .LONG_LEN  (LONG_LEN),
      .SHORT_LEN (SHORT_LEN),
      .GAP_CELLS (GAP_CELLS)
   ) u_ser (
      .clk        (clk),
      .rst_n      (rst_n),
      .cell_end   (cell_end),
      .first_half (first_half),
      .tx_en      (tx_en),
      .fifo_empty (fifo_empty),
      .par_even   (par_even),
      .short_word (short_word),
      .word_in    (head_word),
      .pop        (pop_w),
      .line_hi    (line_hi),
      .line_lo    (line_lo)
   );

   assign bit_clk = first_half;
endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned CNT_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_hi,
   input logic             line_lo,
   input logic             bit_clk,
   input logic             fifo_empty,
   input logic             tx_en,
   input logic             pop,
   input logic             push,
   input logic [CNT_W-1:0] count
);
   AST_LINE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(line_hi && line_lo));                                        // R4
   AST_NULL_HALF: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_clk |-> (!line_hi && !line_lo));                          // R4
   AST_POP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (tx_en && !fifo_empty));                               // R3
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));                                       // R2
   AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH) && !pop) |=> (count == CNT_W'(DEPTH))); // R2
   AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty && !push) |=> fifo_empty);                         // R9
endmodule

bind a429_tx_fifo a429_tx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_hi    (line_hi),
   .line_lo    (line_lo),
   .bit_clk    (bit_clk),
   .fifo_empty (fifo_empty),
   .tx_en      (tx_en),
   .pop        (pop_w),
   .push       (load_hi),
   .count      (fifo_count)
);

// File: tb/sim_a429_tx_fifo.sv
module sim_a429_tx_fifo;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] din = '0;
   logic        load_lo = 1'b0, load_hi = 1'b0, tx_en = 1'b0;
   logic        par_even = 1'b0, short_word = 1'b0;
   logic        line_hi, line_lo, bit_clk, fifo_empty;

   int vectors = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   a429_tx_fifo u0 (
      .clk(clk), .rst_n(rst_n), .din(din), .load_lo(load_lo), .load_hi(load_hi),
      .tx_en(tx_en), .par_even(par_even), .short_word(short_word),
      .line_hi(line_hi), .line_lo(line_lo), .bit_clk(bit_clk), .fifo_empty(fifo_empty)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model, updated on each rising edge
   int          m_ph = 0, m_st = 0, m_idx = 0, m_gap = 0, m_len = 32, m_sz, m_ones;
   bit          m_start;
   logic [31:0] m_frame = '0, m_w;
   logic [15:0] m_half = '0;
   logic [31:0] q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_st = 0; m_idx = 0; m_gap = 0; m_half = '0; q.delete();
      end else begin
         m_sz    = q.size();
         m_start = (m_ph == 9) && tx_en && (m_sz > 0) && (m_st == 0 || (m_st == 2 && m_gap == 3));
         if (load_hi && m_sz < 8) q.push_back({din, m_half});
         if (load_lo) m_half = din;
         if (m_start) begin
            m_w = q.pop_front();
            m_len = short_word ? 25 : 32;
            m_frame = '0; m_ones = 0;
            for (int i = 0; i < m_len - 1; i++) begin
               m_frame[i] = m_w[i];
               m_ones += int'(m_w[i]);
            end
            m_frame[m_len-1] = par_even ? (m_ones % 2 == 1) : (m_ones % 2 == 0);
            m_st = 1; m_idx = 0;
         end else if (m_ph == 9) begin
            if (m_st == 1) begin
               if (m_idx == m_len - 1) begin m_st = 2; m_gap = 0; end
               else m_idx++;
            end else if (m_st == 2) begin
               if (m_gap == 3) m_st = 0; else m_gap++;
            end
         end
         m_ph = (m_ph == 9) ? 0 : m_ph + 1;
      end
   end

   // expected words, {short, par_even, word}
   logic [33:0] expq[$];
   int          rx_words = 0, rx_n = 0, null_run = 0, min_gap = 1000000;
   bit          prev_act = 1'b0, had_word = 1'b0;
   logic [31:0] rx_val = '0;

   task automatic finish_word();
      logic [33:0] e;
      int          len;
      logic [31:0] msk;
      rx_words++;
      if (expq.size() == 0) begin
         chk(1'b0, "R3 unexpected word", rx_val, 32'h0);
      end else begin
         e   = expq.pop_front();
         len = e[33] ? 25 : 32;
         msk = (32'h1 << (len - 1)) - 32'h1;
         chk(rx_n == len, "R6 length", rx_n, len);
         chk((rx_val & msk) == (e[31:0] & msk), "R1 data", rx_val & msk, e[31:0] & msk);
         chk(($countones(rx_val) % 2) == (e[32] ? 0 : 1), "R5 parity", rx_val, {31'h0, e[32]});
      end
      rx_n = 0; rx_val = '0; had_word = 1'b1;
   endtask

   always @(negedge clk) begin
      // per-clock comparison against the model
      vectors++;
      if (line_hi !== (m_st == 1 && m_ph < 5 && m_frame[m_idx] == 1'b1) ||
          line_lo !== (m_st == 1 && m_ph < 5 && m_frame[m_idx] == 1'b0)) begin
         fails++;
         $display("FAIL R4 line act=%b%b exp=%b%b t=%0t", line_hi, line_lo,
                  (m_st == 1 && m_ph < 5 && m_frame[m_idx]), (m_st == 1 && m_ph < 5 && !m_frame[m_idx]), $time);
      end else if (bit_clk !== (m_ph < 5)) begin
         fails++;
         $display("FAIL R8 bit_clk act=%b exp=%b t=%0t", bit_clk, (m_ph < 5), $time);
      end else if (fifo_empty !== (q.size() == 0)) begin
         fails++;
         $display("FAIL R9 empty act=%b exp=%b t=%0t", fifo_empty, (q.size() == 0), $time);
      end
      // line decoder
      if ((line_hi || line_lo) && !prev_act) begin
         if (rx_n == 0 && had_word && null_run < min_gap) min_gap = null_run;
         if (rx_n < 32) rx_val[rx_n] = line_hi;
         rx_n++;
      end
      if (line_hi || line_lo) null_run = 0;
      else begin
         null_run++;
         if (null_run == 15 && rx_n > 0) finish_word();
      end
      prev_act = line_hi || line_lo;
   end

   task automatic strobe_lo(input logic [15:0] d);
      @(negedge clk); din = d; load_lo = 1'b1;
      @(negedge clk); load_lo = 1'b0;
   endtask

   task automatic strobe_hi(input logic [15:0] d);
      @(negedge clk); din = d; load_hi = 1'b1;
      @(negedge clk); load_hi = 1'b0;
   endtask

   task automatic load_word(input logic [31:0] w, input bit sent);
      strobe_lo(w[15:0]);
      strobe_hi(w[31:16]);
      if (sent) expq.push_back({short_word, par_even, w});
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   // raise tx_en together with a high-half strobe one clock before a cell boundary
   task automatic coincide(input logic [15:0] hi);
      forever begin
         @(negedge clk);
         if (m_ph == 9) break;
      end
      tx_en = 1'b1; din = hi; load_hi = 1'b1;
      @(negedge clk); load_hi = 1'b0;
   endtask

   initial begin
      int base;
      wait_clks(3);
      chk(fifo_empty === 1'b1, "R10 empty in reset", fifo_empty, 1);
      chk(!line_hi && !line_lo, "R10 lines null in reset", {line_hi, line_lo}, 0);
      chk(bit_clk === 1'b1, "R10 bit_clk phase in reset", bit_clk, 1);
      rst_n = 1'b1;

      // gating by tx_en, then a 32-bit odd-parity word
      load_word(32'hA5C3_0F1E, 1'b1);
      wait_clks(100);
      chk(fifo_empty === 1'b0 && rx_words == 0, "R3 held while disabled", rx_words, 0);
      tx_en = 1'b1;
      wait_clks(400);
      chk(rx_words == 1, "R3 sent after enable", rx_words, 1);
      chk(fifo_empty === 1'b1, "R9 empty after send", fifo_empty, 1);

      // even parity
      par_even = 1'b1;
      load_word(32'h1234_5678, 1'b1);
      wait_clks(400);
      // 25-bit words, both senses
      short_word = 1'b1;
      load_word(32'hFFFF_FFFF, 1'b1);
      wait_clks(400);
      par_even = 1'b0;
      load_word(32'h00AB_CDEF, 1'b1);
      wait_clks(400);
      chk(rx_words == 4, "R6 short words received", rx_words, 4);

      // push and pop in one clock with one word queued
      short_word = 1'b0; tx_en = 1'b0;
      load_word(32'h0F0F_1111, 1'b1);
      strobe_lo(16'h2222);
      expq.push_back({1'b0, 1'b0, 32'hF0F0_2222});
      coincide(16'hF0F0);
      wait_clks(800);
      chk(rx_words == 6, "R1 coincident push and pop both sent", rx_words, 6);

      // full queue, ninth word dropped in the pop clock
      tx_en = 1'b0; par_even = 1'b1;
      for (int i = 0; i < 8; i++) load_word(32'h3000_0000 + 32'(i * 32'h0101_0101), 1'b1);
      strobe_lo(16'hDEAD);
      base = rx_words;
      coincide(16'hBEEF);
      wait_clks(3100);
      chk(rx_words - base == 8, "R2 only eight words sent", rx_words - base, 8);
      chk(fifo_empty === 1'b1, "R2 overflow word dropped", fifo_empty, 1);

      // word stream with mixed settings while enabled
      for (int i = 0; i < 8; i++) begin
         par_even = i[0]; short_word = i[1];
         load_word(32'h9E37_79B9 * 32'(i + 1), 1'b1);
         wait_clks(400);
      end
      chk(min_gap >= 45, "R7 null gap between words", min_gap, 45);

      // tx_en drop mid-word, then reset clears the remainder
      par_even = 1'b0; short_word = 1'b0; tx_en = 1'b0;
      load_word(32'h7777_AAAA, 1'b1);
      load_word(32'h5555_CCCC, 1'b0);
      base = rx_words;
      tx_en = 1'b1;
      wait_clks(60);
      tx_en = 1'b0;
      wait_clks(600);
      chk(rx_words - base == 1, "R3 started word completes", rx_words - base, 1);
      chk(fifo_empty === 1'b0, "R3 second word held", fifo_empty, 0);
      @(negedge clk); rst_n = 1'b0;
      wait_clks(3);
      chk(fifo_empty === 1'b1, "R10 reset empties queue", fifo_empty, 1);
      chk(bit_clk === 1'b1, "R8 phase restarts in reset", bit_clk, 1);
      rst_n = 1'b1; tx_en = 1'b1;
      wait_clks(500);
      chk(rx_words - base == 1, "R10 nothing sent after reset", rx_words - base, 1);
      chk(expq.size() == 0, "R4 all expected words decoded", expq.size(), 0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog R3 act=running exp=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end
endmodule